// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the network layer of a slave on a single-wire bus. After every bus reset it collects an 8-bit ROM command from the master, one bit per write slot, and then acts on it against a 64-bit identity. The identity is fixed by parameters: a family code, a 48-bit serial number and an 8-bit check byte. By default the check byte is derived from the other two at elaboration time.

Four commands are understood.
- **Read identity** streams the 64 identity bits out.
- **Match** compares 64 written bits with the identity.
- **Skip** needs no identity transfer at all.
- **Search** runs the slave half of the bus enumeration algorithm. For each bit the block sends the identity bit, then its complement, then reads the master's chosen bit. It drops out of the search if the chosen bit differs from its own.

A successful command raises `grant`. This output opens the downstream function layer and holds until the next bus reset. A failed or unknown command leaves the block dormant, with the bus released, until that reset.

The block sits behind a bit engine, which does the slot timing. The engine reports:
- a bus reset with `bus_reset`;
- each master write slot with `wr_stb` and `wr_val`;
- each master read slot with `rd_stb`.

During a read slot the engine drives the bus from `tx_bit`, where 1 means release.

Top module: `idrom_net_layer`

## Requirements
- R1: After a bus reset the block takes the next 8 write-slot bits as the command, the first bit received being the command's bit 0; codes are 33h read identity, 55h match, CCh skip, F0h search.
- R2: After 33h, successive read slots return identity bits 0 to 63: family code bits 0-7, serial bits 8-55, check byte bits 56-63, each field LSB first; `grant` rises the cycle after the 64th read slot.
- R3: After 55h, 64 write slots that equal identity bits 0 to 63 in order raise `grant` the cycle after the 64th slot.
- R4: During match, a written bit that differs from the identity bit makes the block dormant: `grant` stays 0 and `tx_bit` is 1 in every read slot until the next bus reset.
- R5: After CCh, `grant` rises the cycle after the 8th command bit, with no identity bits transferred.
- R6: After F0h, for each of the 64 bits the block returns the identity bit in one read slot and its complement in the next, then takes one write slot. When all 64 written bits agree with the identity, `grant` rises the cycle after the last write.
- R7: During search, a written bit that differs from the identity bit makes the block dormant, as in R4.
- R8: Any command code other than the four in R1 makes the block dormant, as in R4.
- R9: `grant` holds until a bus reset. A bus reset clears `grant` and restarts command collection, and it takes priority over a strobe in the same cycle, which is then ignored.
- R10: The default check byte is the CRC with polynomial x^8+x^5+x^4+1 over identity bits 0-55, LSB first, from a zero start. Shifting all 64 identity bits through that CRC leaves zero.
- R11: `tx_bit` is 1 whenever no identity bit is being sent. Out of `rst_n` (synchronous, active low) the block is dormant: `grant` is 0 and strobes are ignored until the first bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Strobe: bit engine saw a bus reset |
| wr_stb | input | 1 | Strobe: master write slot finished |
| wr_val | input | 1 | Bit value of that write slot |
| rd_stb | input | 1 | Strobe: master read slot finished |
| tx_bit | output | 1 | Value to drive in the current read slot, 1 = release |
| grant | output | 1 | Function layer access enabled |

## Verification
The bench builds the block with the default family code and lets the check byte take its derived default. The serial number is overridden with a value that has both zeros and ones in every byte. This lets the flipped bits used in the match and search failure cases hit an identity 0 and an identity 1, so both directions of the mismatch comparison come within reach. The check byte is recomputed in the bench and compared through the read-identity stream. This ties the elaboration-time CRC to what actually leaves the port.

// File: rtl/idrom_pkg.sv
// Shared constants, types and CRC helpers for the ROM command layer.
// Assumes a 64-bit identity split as family / serial / check byte.
package idrom_pkg;

    localparam int FAM_W = 8;
    localparam int SER_W = 48;
    localparam int CRC_W = 8;
    localparam int ID_W  = FAM_W + SER_W + CRC_W;
    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;

    // Reflected form of x^8 + x^5 + x^4 + 1
    localparam logic [CRC_W-1:0] CRC_TAPS = 8'h8C;

    typedef enum logic [2:0] {
        ST_DORMANT,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_GRANT
    } rom_state_t;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_PICK
    } srch_phase_t;

    // One serial CRC step, data bit enters at the low end
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                   input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_TAPS : '0);
    endfunction

    // CRC over the lowest n bits of v, bit 0 first, zero start
    function automatic logic [CRC_W-1:0] crc_over(input logic [ID_W-1:0] v,
                                                   input int n);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 0; i < n; i++) begin
            c = crc_step(c, v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/idrom_cmd_rx.sv
// Command collector: gathers W write-slot bits, first bit into bit 0.
// Assumes the caller enables it only while a command is expected and
// clears it on every bus reset.
module idrom_cmd_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         en,
    input  logic         wr_stb,
    input  logic         wr_val,
    output logic         fire,
    output logic [W-1:0] word
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = en && wr_stb && !clear;
    assign fire = take && (cnt == CNT_W'(W - 1));
    assign word = {wr_val, shreg[W-1:1]};

    // Shift in command bits and count them
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (take) begin
            shreg <= word;
            cnt   <= fire ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/idrom_cursor.sv
// Identity bit cursor: index of the current identity bit and, for search,
// which of the three slots of that bit is next.
// Assumes step_bit and step_phase are never raised together.
module idrom_cursor
    import idrom_pkg::*;
#(
    parameter int NBITS = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step_bit,
    input  logic                       step_phase,
    output logic [$clog2(NBITS)-1:0]   idx,
    output srch_phase_t                phase,
    output logic                       at_last
);
    localparam int IDX_W = $clog2(NBITS);

    assign at_last = (idx == IDX_W'(NBITS - 1));

    // Advance bit index and search phase
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx   <= '0;
            phase <= PH_TRUE;
        end else if (step_bit) begin
            idx   <= idx + 1'b1;
            phase <= PH_TRUE;
        end else if (step_phase) begin
            phase <= srch_phase_t'(phase + 2'd1);
        end
    end

endmodule

// File: rtl/idrom_net_layer.sv
// ROM command layer: after each bus reset decodes one ROM command and
// runs read, match, skip or search against a parameter identity.
// Assumes strobes are single-cycle and come from a bit engine that
// drives the bus from tx_bit during read slots (1 = release).
module idrom_net_layer
    import idrom_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h1B,
    parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_0000_0001,
    parameter logic [CRC_W-1:0] ID_CRC      =
        crc_over({{CRC_W{1'b0}}, SERIAL_NUM, FAMILY_CODE}, FAM_W + SER_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic wr_stb,
    input  logic wr_val,
    input  logic rd_stb,
    output logic tx_bit,
    output logic grant
);
    localparam int               IDX_W   = $clog2(ID_W);
    localparam logic [ID_W-1:0]  ID_WORD = {ID_CRC, SERIAL_NUM, FAMILY_CODE};

    rom_state_t         state, state_nx;
    logic               grant_nx;
    logic               cur_clr, cur_bit, cur_ph;
    logic [IDX_W-1:0]   idx;
    srch_phase_t        phase;
    logic               at_last;
    logic               id_bit;
    logic               cmd_fire;
    logic [CMD_W-1:0]   cmd_word;

    idrom_cmd_rx #(.W(CMD_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (bus_reset),
        .en     (state == ST_CMD),
        .wr_stb (wr_stb),
        .wr_val (wr_val),
        .fire   (cmd_fire),
        .word   (cmd_word)
    );

    idrom_cursor #(.NBITS(ID_W)) u_cur (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cur_clr),
        .step_bit   (cur_bit),
        .step_phase (cur_ph),
        .idx        (idx),
        .phase      (phase),
        .at_last    (at_last)
    );

    assign id_bit = ID_WORD[idx];

    // Next-state, grant and cursor control
    always_comb begin
        state_nx = state;
        grant_nx = grant;
        cur_clr  = 1'b0;
        cur_bit  = 1'b0;
        cur_ph   = 1'b0;
        if (bus_reset) begin
            state_nx = ST_CMD;
            grant_nx = 1'b0;
            cur_clr  = 1'b1;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (cmd_fire) begin
                        cur_clr = 1'b1;
                        case (cmd_word)
                            CMD_READ:   state_nx = ST_READ;
                            CMD_MATCH:  state_nx = ST_MATCH;
                            CMD_SEARCH: state_nx = ST_SEARCH;
                            CMD_SKIP: begin
                                state_nx = ST_GRANT;
                                grant_nx = 1'b1;
                            end
                            default:    state_nx = ST_DORMANT;
                        endcase
                    end
                end
                ST_READ: begin
                    if (rd_stb) begin
                        if (at_last) begin
                            state_nx = ST_GRANT;
                            grant_nx = 1'b1;
                        end else begin
                            cur_bit = 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (wr_stb) begin
                        if (wr_val != id_bit) begin
                            state_nx = ST_DORMANT;
                        end else if (at_last) begin
                            state_nx = ST_GRANT;
                            grant_nx = 1'b1;
                        end else begin
                            cur_bit = 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (phase != PH_PICK) begin
                        cur_ph = rd_stb;
                    end else if (wr_stb) begin
                        if (wr_val != id_bit) begin
                            state_nx = ST_DORMANT;
                        end else if (at_last) begin
                            state_nx = ST_GRANT;
                            grant_nx = 1'b1;
                        end else begin
                            cur_bit = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State and grant registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DORMANT;
            grant <= 1'b0;
        end else begin
            state <= state_nx;
            grant <= grant_nx;
        end
    end

    // Bus drive value for the current read slot
    always_comb begin
        tx_bit = 1'b1;
        if (state == ST_READ) begin
            tx_bit = id_bit;
        end else if (state == ST_SEARCH) begin
            if (phase == PH_TRUE)      tx_bit = id_bit;
            else if (phase == PH_COMP) tx_bit = !id_bit;
        end
    end

endmodule

// Property checker for the ROM command layer, bound to every instance.
module idrom_net_layer_chk
    import idrom_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_reset,
    input logic            rd_stb,
    input logic            tx_bit,
    input logic            grant,
    input rom_state_t      state,
    input srch_phase_t     phase,
    input logic [ID_W-1:0] id_word
);
    // R9: grant holds until a bus reset
    assert_grant_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !bus_reset |=> grant);

    // R9: a bus reset clears grant and releases the bus
    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !grant && tx_bit && state == ST_CMD);

    // R6: the slot after the true bit carries its complement
    assert_search_comp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEARCH && phase == PH_TRUE && rd_stb && !bus_reset
        |=> tx_bit == !$past(tx_bit));

    // R11: bus released whenever no identity bit is sent
    assert_bus_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_CMD, ST_MATCH, ST_GRANT, ST_DORMANT} |-> tx_bit);

    // R8: dormant persists without grant until a bus reset
    assert_dormant_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DORMANT && !bus_reset |=> state == ST_DORMANT && !grant);

    // R10: the whole identity leaves a zero CRC residue
    always @(posedge clk) begin
        if (rst_n) begin
            assert_crc_residue_R10: assert (crc_over(id_word, ID_W) == '0);
        end
    end

endmodule

bind idrom_net_layer idrom_net_layer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .rd_stb    (rd_stb),
    .tx_bit    (tx_bit),
    .grant     (grant),
    .state     (state),
    .phase     (phase),
    .id_word   (ID_WORD)
);

// File: tb/test_idrom_net_layer.sv
// Scoreboard bench: driver tasks queue the expected bus value of each
// read slot, a negedge monitor pops and compares.
module test_idrom_net_layer;

    localparam logic [7:0]  FAM = 8'h1B;
    localparam logic [47:0] SER = 48'h9C3A_5E0F_71B6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic wr_stb = 1'b0;
    logic wr_val = 1'b0;
    logic rd_stb = 1'b0;
    logic tx_bit;
    logic grant;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic  exp_q[$];
    string req_q[$];
    logic [63:0] exp_id;

    idrom_net_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) i_idrom_net_layer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .wr_stb    (wr_stb),
        .wr_val    (wr_val),
        .rd_stb    (rd_stb),
        .tx_bit    (tx_bit),
        .grant     (grant)
    );

    always #10 clk = ~clk;

    function automatic void tally(input bit ok, input string req,
                                  input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endfunction

    // Bench-side CRC, written as explicit register equations
    function automatic logic [7:0] bench_crc(input logic [63:0] v, input int n);
        logic [7:0] c, d;
        logic m;
        c = 8'h00;
        for (int i = 0; i < n; i++) begin
            m = c[0] ^ v[i];
            d = {m, c[7], c[6], c[5], c[4] ^ m, c[3] ^ m, c[2], c[1]};
            c = d;
        end
        return c;
    endfunction

    // Monitor: compare every read slot with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            if (exp_q.size() == 0) begin
                tally(1'b0, "R11 unexpected slot", 8'(tx_bit), 8'hFF);
            end else begin
                logic e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                tally(tx_bit == e, r, 8'(tx_bit), 8'(e));
            end
        end
    end

    task automatic pulse_wr(input logic v);
        wr_val = v;
        wr_stb = 1'b1;
        @(posedge clk); #2;
        wr_stb = 1'b0;
    endtask

    task automatic rd_slot(input logic e, input string req);
        exp_q.push_back(e);
        req_q.push_back(req);
        rd_stb = 1'b1;
        @(posedge clk); #2;
        rd_stb = 1'b0;
    endtask

    task automatic do_bus_reset();
        bus_reset = 1'b1;
        @(posedge clk); #2;
        bus_reset = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) pulse_wr(b[i]);
    endtask

    task automatic check_grant(input logic e, input string req);
        @(negedge clk);
        tally(grant == e, req, 8'(grant), 8'(e));
        @(posedge clk); #2;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            tally(1'b0, "watchdog", 8'h0, 8'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        exp_id = {bench_crc({8'h0, SER, FAM}, 56), SER, FAM};
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R11: reset state
        @(negedge clk);
        tally(grant == 1'b0 && tx_bit == 1'b1, "R11 reset state", {grant, tx_bit}, 8'h01);
        @(posedge clk); #2;

        // R11: a skip before any bus reset is ignored
        send_byte(8'hCC);
        check_grant(1'b0, "R11 ignored before bus reset");
        rd_slot(1'b1, "R11 dormant read slot");

        // R10: identity CRC residue
        tally(bench_crc(exp_id, 64) == 8'h00, "R10 residue", bench_crc(exp_id, 64), 8'h00);

        // R5: skip grants after 8 bits
        do_bus_reset();
        send_byte(8'hCC);
        check_grant(1'b1, "R5 skip grant");
        // R9/R11: grant holds, strobes ignored, bus released
        pulse_wr(1'b0);
        rd_slot(1'b1, "R11 release while granted");
        check_grant(1'b1, "R9 grant holds");
        do_bus_reset();
        check_grant(1'b0, "R9 bus reset clears grant");

        // R2/R10: read identity streams all 64 bits
        send_byte(8'h33);
        check_grant(1'b0, "R1 33h is not skip");
        for (int i = 0; i < 64; i++) rd_slot(exp_id[i], i >= 56 ? "R10 check byte" : "R2 read bit");
        check_grant(1'b1, "R2 read grant");

        // R3: exact match
        do_bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) pulse_wr(exp_id[i]);
        check_grant(1'b1, "R3 match grant");

        // R4: match mismatch at a 1 bit and at a 0 bit
        for (int k = 0; k < 2; k++) begin
            int fl;
            fl = (k == 0) ? 1 : 32;
            do_bus_reset();
            send_byte(8'h55);
            for (int i = 0; i <= fl; i++) pulse_wr(exp_id[i] ^ (i == fl));
            rd_slot(1'b1, "R4 dormant release");
            for (int i = fl + 1; i < 64; i++) pulse_wr(exp_id[i]);
            check_grant(1'b0, "R4 no grant after mismatch");
        end

        // R6: full search pass
        do_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd_slot(exp_id[i], "R6 search true bit");
            rd_slot(!exp_id[i], "R6 search complement");
            pulse_wr(exp_id[i]);
        end
        check_grant(1'b1, "R6 search grant");

        // R7: search deselection at bit 10
        do_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 10; i++) begin
            rd_slot(exp_id[i], "R6 search true bit");
            rd_slot(!exp_id[i], "R6 search complement");
            pulse_wr(exp_id[i]);
        end
        rd_slot(exp_id[10], "R6 search true bit");
        rd_slot(!exp_id[10], "R6 search complement");
        pulse_wr(!exp_id[10]);
        rd_slot(1'b1, "R7 deselected release");
        rd_slot(1'b1, "R7 deselected release");
        check_grant(1'b0, "R7 no grant after deselect");

        // R8: unknown command
        do_bus_reset();
        send_byte(8'hA5);
        rd_slot(1'b1, "R8 unknown release");
        check_grant(1'b0, "R8 unknown no grant");

        // R9: bus reset wins over a same-cycle write strobe
        bus_reset = 1'b1;
        wr_val = 1'b1;
        wr_stb = 1'b1;
        @(posedge clk); #2;
        bus_reset = 1'b0;
        wr_stb = 1'b0;
        send_byte(8'hCC);
        check_grant(1'b1, "R9 strobe ignored during bus reset");

        repeat (2) @(posedge clk);
        tally(exp_q.size() == 0, "R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule